// File: doc/BRIEF.md
# Parallel Program Cycle Controller

This block runs the byte-wide load cycles of a microcontroller that is held in its load state. Each clock it reads the reset pin, the program-store enable, the program strobe, the external-access pin with its high-voltage detect, and the three mode bits taken from the top of port 2. From these it picks the cycle type. The types are: normal program, security set, normal verify, expanded program, expanded verify, and register program or verify. Program-type cycles act once, on the falling edge of the strobe. They write one byte to embedded memory, or to the configuration register, or to one of the key registers. Verify cycles drive the addressed byte back onto the data port for as long as their pin pattern is held.

After power-on reset, the first normal-program or security-set strobe also loads a default memory layout into the configuration register. That layout is an 8 KB range with 4 KB of program and 4 KB of data. The block does this only once until the next power-on reset. Writes keep the block busy for a fixed number of clocks, and expanded writes keep it busy longer.

Top module: `ppc_ctrl`

## Requirements
- R1: After power-on reset (rst_n low) the outputs are as follows. cfg_out equals CFG_INIT (8'hF8). key_out is zero. mem_we, mem_re, port_doe, busy and init_done are all 0.
- R2: Normal program: pin_rst=1, pin_psen=0, pin_ea_vpp=1 and mode_sel=3'b10x (mode_sel[2] is P2.7, [1] is P2.6, [0] is P2.5). On a strobe, mem_we is high for exactly the one cycle after the edge. In that cycle mem_addr is {3'b000, port_addr[11:0]} and mem_wdata is port_din.
- R3: A pin pattern that matches no cycle type changes no memory, no register and no output. This includes patterns where pin_rst=0.
- R4: Security set (program pins with mode_sel=3'b11x) sets cfg_out[0] and writes no memory.
- R5: On the first normal-program or security-set strobe after power-on reset, cfg_out[7:4] becomes 1, cfg_out[3] becomes 0 and init_done becomes 1. Later strobes do not repeat this. A new power-on reset re-arms it.
- R6: Expanded program (program pins with mode_sel=3'b010) writes to the full 15-bit port_addr. busy stays high for EXP_CYC cycles after an expanded write and for NORM_CYC cycles after any other write.
- R7: Normal verify needs pin_rst=1, pin_ea=1, pin_ea_vpp=0 and mode_sel=3'b00x. Expanded verify needs pin_psen=0, pin_prog=1 and mode_sel=3'b010, with the same reset and EA levels. One cycle later, port_doe is 1 and port_dout equals mem_rdata. mem_addr is the 12-bit address for normal verify and the 15-bit address for expanded verify.
- R8: Register program uses program pins with mode_sel=3'b011. It only acts when port_addr[14:8]=0 and port_addr[7:0]=REG_BASE+k with k from 0 to 5. k=0 writes the configuration register. k=1..5 writes key byte k-1, which is key_out[8(k-1)+:8]. Any other address is ignored.
- R9: Register verify uses the verify pins with pin_psen=0, pin_prog=1 and mode_sel=3'b011. It returns cfg_out for offset 0 and 8'h00 for the key offsets. Key bytes cannot be read back.
- R10: A write starts only on a high-to-low change of pin_prog. Holding pin_prog low does not repeat the write. A falling edge while busy is high is ignored.
- R11: Once cfg_out[0] (the security lock) is set, it stays set until power-on reset, even when a register write carries bit 0 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| pin_rst | input | 1 | Reset pin level, must be 1 for any cycle |
| pin_psen | input | 1 | Program-store enable pin level |
| pin_prog | input | 1 | Program strobe, active low |
| pin_ea | input | 1 | External-access pin logic level |
| pin_ea_vpp | input | 1 | External-access pin is at programming voltage |
| mode_sel | input | 3 | Port 2 bits 7,6,5 |
| port_addr | input | AW | Address from ports 1 and 2 |
| port_din | input | 8 | Data to program |
| port_dout | output | 8 | Verify read data |
| port_doe | output | 1 | Verify data valid, drive enable |
| busy | output | 1 | Write in progress |
| mem_we | output | 1 | Embedded memory write strobe |
| mem_re | output | 1 | Embedded memory read enable |
| mem_addr | output | AW | Embedded memory address |
| mem_wdata | output | 8 | Embedded memory write data |
| mem_rdata | input | 8 | Embedded memory read data, combinational from mem_addr |
| cfg_out | output | 8 | Configuration register |
| key_out | output | 8*NKEY | Key register bytes |
| init_done | output | 1 | Default layout already applied |

## Verification
A wrong internal decode or a stale edge detector appears at the ports one clock after the strobe edge. It shows as a missing, doubled or misaddressed mem_we pulse, or as a configuration or key byte that changed when it should not. A broken busy counter shows in the length of the busy window, and also in a second strobe being accepted while busy is high. A lost init flag shows as the layout bits being rewritten by a later strobe. A bad verify selection shows on port_dout and port_doe in the cycle after the pins settle.

// File: rtl/ppc_ctrl.sv
module ppc_ctrl #(
  parameter int AW       = 15,
  parameter int NAW      = 12,
  parameter int NKEY     = 5,
  parameter int NORM_CYC = 4,
  parameter int EXP_CYC  = 16,
  parameter logic [7:0] REG_BASE = 8'h80,
  parameter logic [7:0] CFG_INIT = 8'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_rst,
  input  logic              pin_psen,
  input  logic              pin_prog,
  input  logic              pin_ea,
  input  logic              pin_ea_vpp,
  input  logic [2:0]        mode_sel,
  input  logic [AW-1:0]     port_addr,
  input  logic [7:0]        port_din,
  output logic [7:0]        port_dout,
  output logic              port_doe,
  output logic              busy,
  output logic              mem_we,
  output logic              mem_re,
  output logic [AW-1:0]     mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        cfg_out,
  output logic [8*NKEY-1:0] key_out,
  output logic              init_done
);
  localparam int CW = $clog2(EXP_CYC + 1);
  localparam logic [CW-1:0] NORM_LD = CW'(NORM_CYC);
  localparam logic [CW-1:0] EXP_LD  = CW'(EXP_CYC);

  logic          prog_q;
  logic [CW-1:0] cnt;
  logic [7:0]    cfg_q;
  logic [7:0]    key_q [NKEY];
  logic          rd_reg_q;
  logic [7:0]    reg_val_q;

  wire ea_hi = pin_ea & ~pin_ea_vpp;
  wire pg_ok = pin_rst & ~pin_psen & ~pin_prog & pin_ea_vpp;
  wire vx_ok = pin_rst & ~pin_psen & pin_prog & ea_hi;

  wire m_prog  = pg_ok & mode_sel[2] & ~mode_sel[1];
  wire m_sec   = pg_ok & mode_sel[2] & mode_sel[1];
  wire m_xprog = pg_ok & (mode_sel == 3'b010);
  wire m_rprog = pg_ok & (mode_sel == 3'b011);
  wire m_ver   = pin_rst & ea_hi & (mode_sel[2:1] == 2'b00);
  wire m_xver  = vx_ok & (mode_sel == 3'b010);
  wire m_rver  = vx_ok & (mode_sel == 3'b011);

  wire [7:0] off     = port_addr[7:0] - REG_BASE;
  wire       reg_hit = (port_addr[AW-1:8] == '0) && (port_addr[7:0] >= REG_BASE) &&
                       (off <= 8'(NKEY));

  assign busy = (cnt != '0);
  wire fall = prog_q & ~pin_prog;
  wire go   = fall & ~busy & (m_prog | m_sec | m_xprog | (m_rprog & reg_hit));
  wire go_mem = go & (m_prog | m_xprog);
  wire go_cfg = go & m_rprog & (off == 8'd0);

  wire [AW-1:0] nrm_addr = {{(AW-NAW){1'b0}}, port_addr[NAW-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= 1'b1;
      cnt    <= '0;
    end else begin
      prog_q <= pin_prog;
      if (go)        cnt <= m_xprog ? EXP_LD : NORM_LD;
      else if (busy) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= CFG_INIT;
      init_done <= 1'b0;
    end else begin
      if (go & (m_prog | m_sec) & ~init_done) begin
        cfg_q[7:3] <= 5'b00010;
        init_done  <= 1'b1;
      end
      if (go & m_sec) cfg_q[0] <= 1'b1;
      if (go_cfg)     cfg_q <= {port_din[7:1], port_din[0] | cfg_q[0]};
    end
  end

  for (genvar k = 0; k < NKEY; k++) begin : g_key
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    key_q[k] <= 8'h00;
      else if (go & m_rprog & (off == 8'(k + 1)))    key_q[k] <= port_din;
    end
    assign key_out[8*k +: 8] = key_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= 8'h00;
      port_doe  <= 1'b0;
      rd_reg_q  <= 1'b0;
      reg_val_q <= 8'h00;
    end else begin
      mem_we   <= go_mem;
      mem_re   <= m_ver | m_xver;
      port_doe <= m_ver | m_xver | (m_rver & reg_hit);
      rd_reg_q <= m_rver & reg_hit;
      reg_val_q <= (off == 8'd0) ? cfg_q : 8'h00;
      if (go_mem) begin
        mem_addr  <= m_xprog ? port_addr : nrm_addr;
        mem_wdata <= port_din;
      end else if (m_ver) begin
        mem_addr <= nrm_addr;
      end else if (m_xver) begin
        mem_addr <= port_addr;
      end
    end
  end

  assign port_dout = rd_reg_q ? reg_val_q : mem_rdata;
  assign cfg_out   = cfg_q;

  p_we_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  p_we_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  p_we_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !port_doe);
  p_init_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_out[0] |=> cfg_out[0]);
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= EXP_LD);
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_wdata));
endmodule

// File: tb/ppc_ctrl_tb_top.sv
module ppc_ctrl_tb_top;
  localparam int NORM = 4;
  localparam int EXPC = 16;
  localparam logic [7:0] BASE = 8'h80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic r_rst = 1'b0, r_psen = 1'b1, r_prog = 1'b1, r_ea = 1'b0, r_vpp = 1'b0;
  logic [2:0]  r_mode = 3'b000;
  logic [14:0] r_addr = '0;
  logic [7:0]  r_din = 8'h00;
  logic [7:0]  port_dout, mem_wdata, mem_rdata, cfg_out;
  logic        port_doe, busy, mem_we, mem_re, init_done;
  logic [14:0] mem_addr;
  logic [39:0] key_out;

  int checks = 0, errors = 0, last_busy = 0;
  logic [7:0]  exp_cfg;
  logic [39:0] exp_key;
  logic        exp_init;

  always #5 clk = ~clk;

  ppc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pin_rst(r_rst), .pin_psen(r_psen), .pin_prog(r_prog),
    .pin_ea(r_ea), .pin_ea_vpp(r_vpp), .mode_sel(r_mode), .port_addr(r_addr),
    .port_din(r_din), .port_dout(port_dout), .port_doe(port_doe), .busy(busy),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .cfg_out(cfg_out), .key_out(key_out), .init_done(init_done)
  );

  function automatic logic [7:0] memf(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction
  assign mem_rdata = memf(mem_addr);

  // 0 none, 1 prog, 2 sec, 3 xprog, 4 rprog, 5 ver, 6 xver, 7 rver
  function automatic int kind(input logic rs, ps, pg, ea, vp, input logic [2:0] m);
    if (!rs) return 0;
    if (vp && !ps && !pg) begin
      if (m[2:1] == 2'b10) return 1;
      if (m[2:1] == 2'b11) return 2;
      if (m == 3'b010) return 3;
      if (m == 3'b011) return 4;
      return 0;
    end
    if (ea && !vp) begin
      if (m[2:1] == 2'b00) return 5;
      if (!ps && pg && m == 3'b010) return 6;
      if (!ps && pg && m == 3'b011) return 7;
    end
    return 0;
  endfunction

  function automatic int reg_off(input logic [14:0] a);
    if (a[14:8] != 0 || a[7:0] < BASE || (a[7:0] - BASE) > 5) return -1;
    return int'(a[7:0] - BASE);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; r_prog = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    exp_cfg = 8'hF8; exp_key = '0; exp_init = 1'b0;
  endtask

  task automatic trial(input logic rs, ps, ea, vp, input logic [2:0] m,
                       input logic [14:0] a, input logic [7:0] d, input logic strobe);
    int kv, kw, off;
    logic wr;
    @(negedge clk);
    r_rst = rs; r_psen = ps; r_ea = ea; r_vpp = vp; r_mode = m; r_addr = a; r_din = d; r_prog = 1'b1;
    @(negedge clk);
    kv = kind(rs, ps, 1'b1, ea, vp, m);
    off = reg_off(a);
    if (kv == 5 || kv == 6) begin
      chk("R7 doe", port_doe, 1);
      chk("R7 addr", mem_addr, (kv == 5) ? {3'b000, a[11:0]} : a);
      chk("R7 dout", port_dout, (kv == 5) ? memf({3'b000, a[11:0]}) : memf(a));
    end else if (kv == 7 && off >= 0) begin
      chk("R9 doe", port_doe, 1);
      chk("R9 dout", port_dout, (off == 0) ? exp_cfg : 8'h00);
    end else begin
      chk("R3 no doe", port_doe, 0);
    end
    r_prog = strobe ? 1'b0 : 1'b1;
    kw = kind(rs, ps, r_prog, ea, vp, m);
    wr = strobe && (kw == 1 || kw == 2 || kw == 3 || (kw == 4 && off >= 0));
    @(negedge clk);
    chk("R2 we", mem_we, wr && (kw == 1 || kw == 3));
    if (wr && kw == 1) begin
      chk("R2 addr", mem_addr, {3'b000, a[11:0]});
      chk("R2 data", mem_wdata, d);
    end
    if (wr && kw == 3) begin
      chk("R6 addr", mem_addr, a);
      chk("R6 data", mem_wdata, d);
    end
    if (wr) begin
      if ((kw == 1 || kw == 2) && !exp_init) begin
        exp_cfg[7:3] = 5'b00010; exp_init = 1'b1;
      end
      if (kw == 2) exp_cfg[0] = 1'b1;
      if (kw == 4 && off == 0) exp_cfg = {d[7:1], d[0] | exp_cfg[0]};
      if (kw == 4 && off > 0) exp_key[8*(off-1) +: 8] = d;
    end
    chk("R8 cfg", cfg_out, exp_cfg);
    chk("R8 key", key_out, exp_key);
    chk("R5 init", init_done, exp_init);
    r_prog = 1'b1;
    last_busy = 0;
    while (busy && last_busy < 64) begin
      last_busy++;
      @(negedge clk);
    end
    if (wr) chk("R6 busy len", last_busy, (kw == 3) ? EXPC : NORM);
    else    chk("R3 busy", last_busy, 0);
  endtask

  initial begin
    int cnt_we;
    do_reset();
    chk("R1 cfg", cfg_out, 8'hF8);
    chk("R1 key", key_out, 0);
    chk("R1 ctl", {mem_we, mem_re, port_doe, busy, init_done}, 0);

    trial(1, 0, 0, 1, 3'b100, 15'h7ABC, 8'h3C, 1);     // R2 R5
    chk("R5 layout", cfg_out, 8'h10);
    trial(1, 0, 0, 1, 3'b010, 15'h5123, 8'hE1, 1);     // R6
    trial(1, 0, 0, 1, 3'b011, {7'h0, BASE}, 8'hA6, 1); // R8 cfg
    trial(1, 0, 0, 1, 3'b101, 15'h0001, 8'h11, 1);     // R5 no re-init
    chk("R5 kept", cfg_out, 8'hA6);
    trial(1, 0, 0, 1, 3'b011, {7'h0, BASE + 8'd3}, 8'h77, 1); // R8 key
    trial(1, 0, 0, 1, 3'b011, {7'h0, BASE + 8'd6}, 8'h99, 1); // R8 ignored
    trial(1, 0, 0, 1, 3'b011, {7'h1, BASE}, 8'h99, 1);        // R8 ignored
    trial(1, 0, 1, 0, 3'b011, {7'h0, BASE}, 8'h00, 0);        // R9
    trial(1, 0, 1, 0, 3'b011, {7'h0, BASE + 8'd3}, 8'h00, 0); // R9 key hidden
    trial(1, 1, 1, 0, 3'b000, 15'h6F0F, 8'h00, 0);            // R7
    trial(1, 0, 1, 0, 3'b010, 15'h6F0F, 8'h00, 0);            // R7 expanded
    trial(0, 0, 0, 1, 3'b100, 15'h0123, 8'h55, 1);            // R3 pin_rst low
    trial(1, 0, 0, 1, 3'b110, 15'h0000, 8'h00, 1);            // R4
    chk("R4 lock", cfg_out[0], 1);
    trial(1, 0, 0, 1, 3'b011, {7'h0, BASE}, 8'h40, 1);        // R11
    chk("R11 lock kept", cfg_out[0], 1);

    // R10 held low and strobe during busy
    @(negedge clk);
    r_rst = 1; r_psen = 0; r_ea = 0; r_vpp = 1; r_mode = 3'b100; r_addr = 15'h0222; r_din = 8'h5C;
    @(negedge clk); r_prog = 1'b0;
    cnt_we = 0;
    repeat (12) begin @(negedge clk); if (mem_we) cnt_we++; end
    chk("R10 held low", cnt_we, 1);
    r_prog = 1'b1;
    @(negedge clk); r_prog = 1'b0;
    @(negedge clk); r_prog = 1'b1; r_din = 8'hC3;
    @(negedge clk); r_prog = 1'b0;
    @(negedge clk);
    chk("R10 busy reject", mem_we, 0);
    r_prog = 1'b1;
    repeat (EXPC + 2) @(negedge clk);

    do_reset();
    chk("R11 reset clears", cfg_out, 8'hF8);
    chk("R5 rearm", init_done, 0);
    trial(1, 0, 0, 1, 3'b111, 15'h0000, 8'h00, 1);            // R5 R4
    chk("R5 sec init", cfg_out, 8'h11);

    for (int i = 0; i < 300; i++) begin
      logic [14:0] a;
      logic [1:0] eav;
      eav = 2'($urandom_range(0, 3));
      a = ($urandom_range(0, 1) == 1) ? {7'h0, BASE + 8'($urandom_range(0, 7))} : 15'($urandom);
      trial(($urandom_range(0, 9) != 0), 1'($urandom), eav[0], eav[1], 3'($urandom),
            a, 8'($urandom), ($urandom_range(0, 4) != 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule